// File: doc/BRIEF.md
# Edge-Latched Interrupt Aggregator

This block merges a parameterised number of downstream interrupt lines into one upstream interrupt request. Every line is brought into the local clock domain through a two-stage synchroniser. A rising transition on a line then latches a pending bit in a cause register. The bit latches even while the line is disabled, and it stays set after the line falls again. A mask register selects which pending bits may drive the upstream request.

Software uses a small register port with a request strobe, a write enable, a 2-bit address and 32-bit data. It reads the cause and mask registers and writes them. A write to the cause register clears every bit written as zero and keeps every bit written as one. Software can therefore acknowledge exactly the sources it has serviced and will not lose an edge that arrives in the meantime. Because cause bits latch while masked, a driver clears a stale cause bit before it sets the matching mask bit.

Top module: `edge_irq_collector`

## Requirements
- R1: A cause bit sets on a low-to-high transition of its input line. The new value is visible at the register port after the third rising clock edge following the input change. A line that stays high does not set the bit again once the bit has been cleared.
- R2: A cause bit sets on a rising edge whatever the value of the matching mask bit.
- R3: `irq_o` is 1 exactly when at least one bit position has both cause and mask at 1.
- R4: A write to the cause register (address 0) clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R5: If a detected edge and a clearing write reach the same cause bit in the same cycle, the bit ends up set.
- R6: A write to the mask register (address 1) stores the written bits. A mask bit of 1 enables that source and a mask bit of 0 disables it. The value reads back at address 1.
- R7: After reset, cause and mask read as zero and `irq_o` is 0.
- R8: Clearing a cause bit and then setting its mask bit does not raise `irq_o` from the earlier edge. A later new edge does raise it. Writing zero to the mask and then to the cause register leaves the block quiet.
- R9: Read-data bits at and above `NUM_SRC` are 0. Addresses 2 and 3 read as 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Downstream interrupt lines, asynchronous |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | 0 = cause, 1 = mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Upstream interrupt request |

## Verification
A lost or extra cause bit shows up at the next read of address 0. It also shows up on `irq_o` within the same cycle whenever that bit is enabled. A stuck stage in the edge path shifts the visible set point away from the third clock edge, which the directed latency check detects. An edge that is wrongly suppressed during a clearing write shows up one cycle after the collision as a missing bit. A mask that fails to hold its value changes `irq_o` while the lines are idle, and the following readback of address 1 also exposes it.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned REG_DATA_W = 32;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_CAUSE = 2'd0,
    RA_MASK  = 2'd1
  } reg_addr_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q, stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eic_edge.sv
module eic_edge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q, prev_d;

  assign prev_d = lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R1: a rising edge produces a pulse of exactly one cycle per bit
  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/eic_regs.sv
module eic_regs #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic               wr_cause_i,
  input  logic               wr_mask_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] cause_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] cause_q, cause_d, mask_q, mask_d;
  logic               cause_en, mask_en;

  always_comb begin
    cause_en = wr_cause_i | (|rise_i);
    cause_d  = cause_q;
    if (wr_cause_i) cause_d = cause_q & wdata_i;
    cause_d  = cause_d | rise_i;
    mask_en  = wr_mask_i;
    mask_d   = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;

  // R4: bits written as zero are cleared unless an edge arrived
  a_r4_write_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cause_i |=> ((cause_q & ~$past(wdata_i) & ~$past(rise_i)) == '0));
  // R5: a detected edge always leaves its bit set
  a_r5_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((cause_q & $past(rise_i)) == $past(rise_i)));
  // R1: without an edge no cause bit can rise
  a_r1_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i == '0) |=> ((cause_q & ~$past(cause_q)) == '0));
  // R6: mask holds when not written
  a_r6_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_q));
endmodule

// File: rtl/edge_irq_collector.sv
module edge_irq_collector
  import eic_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  reg_req_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [REG_DATA_W-1:0] reg_wdata_i,
  output logic [REG_DATA_W-1:0] reg_rdata_o,
  output logic                  irq_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n;
  logic [NUM_SRC-1:0] src_sync, rise, cause, mask;
  logic               wr_cause, wr_mask;
  logic               unused_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  eic_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(src_i), .q_o(src_sync));

  eic_edge #(.WIDTH(NUM_SRC)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_n), .lvl_i(src_sync), .rise_o(rise));

  assign wr_cause = reg_req_i & reg_we_i & (reg_addr_i == RA_CAUSE);
  assign wr_mask  = reg_req_i & reg_we_i & (reg_addr_i == RA_MASK);
  assign unused_wdata = ^reg_wdata_i;

  eic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .rise_i(rise),
    .wr_cause_i(wr_cause), .wr_mask_i(wr_mask),
    .wdata_i(reg_wdata_i[NUM_SRC-1:0]),
    .cause_o(cause), .mask_o(mask));

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CAUSE: reg_rdata_o[NUM_SRC-1:0] = cause;
      RA_MASK:  reg_rdata_o[NUM_SRC-1:0] = mask;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(cause & mask);

  // R3: no request while every source is disabled
  a_r3_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
  // R3: a request always has a pending cause behind it
  a_r3_irq_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (cause != '0));
endmodule

// File: tb/edge_irq_collector_bench.sv
`timescale 1ns/1ps
module edge_irq_collector_bench;
  localparam int unsigned N = 8;
  localparam logic [31:0] VALID = (32'd1 << N) - 32'd1;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [N-1:0] src;
  logic        req, we;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] exp_cause, exp_mask, rd;

  always #2.5 clk = ~clk;

  edge_irq_collector #(.NUM_SRC(N)) u_edge_irq_collector (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .reg_req_i(req),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic exp_irq(input logic [31:0] c, input logic [31:0] m);
    return |(c & m);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; src = '0; req = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0;
    exp_cause = '0; exp_mask = '0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state
    peek(2'd0, rd); check("R7 cause", rd, 32'h0);
    peek(2'd1, rd); check("R7 mask", rd, 32'h0);
    check("R7 irq", {31'b0, irq}, 32'h0);

    // R1 latency: visible after third posedge
    @(negedge clk); src[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    peek(2'd0, rd); check("R1 not yet", rd, 32'h0);
    @(posedge clk); @(negedge clk);
    peek(2'd0, rd); check("R1 set", rd, 32'h1);
    // R2 masked edge still latched, no request
    check("R2 irq masked", {31'b0, irq}, 32'h0);
    // R3 unmask drives request
    bus_write(2'd1, 32'h1);
    check("R3 irq on", {31'b0, irq}, 32'h1);
    // R4 write ones keeps, zeros clear
    bus_write(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, rd); check("R4 ones keep", rd, 32'h1);
    bus_write(2'd0, 32'h0);
    peek(2'd0, rd); check("R4 zero clears", rd, 32'h0);
    check("R3 irq off", {31'b0, irq}, 32'h0);
    settle();
    peek(2'd0, rd); check("R1 held level no reset", rd, 32'h0);

    // R5 collision: edge and clear in the same cycle
    @(negedge clk); src[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 2'd0; wdata = 32'h0;
    @(negedge clk); req = 1'b0; we = 1'b0;
    peek(2'd0, rd); check("R5 edge wins", rd, 32'h2);

    // R8 clear stale then unmask
    bus_write(2'd1, 32'h0);
    @(negedge clk); src[2] = 1'b1;
    settle();
    peek(2'd0, rd); check("R2 masked latch", rd, 32'h6);
    bus_write(2'd0, 32'h0);
    bus_write(2'd1, 32'h4);
    check("R8 no stale irq", {31'b0, irq}, 32'h0);
    @(negedge clk); src[2] = 1'b0;
    settle();
    @(negedge clk); src[2] = 1'b1;
    settle();
    check("R8 new edge irq", {31'b0, irq}, 32'h1);
    bus_write(2'd1, 32'h0);
    bus_write(2'd0, 32'h0);
    peek(2'd0, rd); check("R8 quiesce cause", rd, 32'h0);
    peek(2'd1, rd); check("R8 quiesce mask", rd, 32'h0);
    check("R8 quiesce irq", {31'b0, irq}, 32'h0);

    // R6 / R9
    bus_write(2'd1, 32'hFFFF_FFFF);
    peek(2'd1, rd); check("R9 upper bits zero", rd, VALID);
    bus_write(2'd2, 32'h0);
    bus_write(2'd3, 32'h0);
    peek(2'd1, rd); check("R9 unmapped write ignored", rd, VALID);
    peek(2'd2, rd); check("R9 addr2 reads zero", rd, 32'h0);
    peek(2'd3, rd); check("R9 addr3 reads zero", rd, 32'h0);
    bus_write(2'd1, 32'h5A);
    peek(2'd1, rd); check("R6 mask readback", rd, 32'h5A);
    exp_mask = 32'h5A;

    // random phase: lines stable during writes
    exp_cause = 32'h0;
    @(negedge clk); src = '0;
    settle();
    bus_write(2'd0, 32'h0);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] nsrc, w;
      int op;
      nsrc = $urandom & VALID;
      @(negedge clk);
      exp_cause = exp_cause | (nsrc & ~{{(32-N){1'b0}}, src});
      src = nsrc[N-1:0];
      settle();
      peek(2'd0, rd); check("R1 random edges", rd, exp_cause);
      op = int'($urandom % 3);
      w = $urandom;
      if (op == 0) begin
        bus_write(2'd1, w); exp_mask = w & VALID;
      end else if (op == 1) begin
        bus_write(2'd0, w); exp_cause = exp_cause & w;
      end
      peek(2'd0, rd); check("R4 random cause", rd, exp_cause);
      peek(2'd1, rd); check("R6 random mask", rd, exp_mask);
      check("R3 random irq", {31'b0, irq}, {31'b0, exp_irq(exp_cause, exp_mask)});
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule